// File: doc/BRIEF.md
# Decimal Digit Adder with Six-Correction

This block adds two binary-coded decimal digits and an incoming carry, and returns one decimal sum digit together with a decimal carry. It has no clock and no state, so the result follows the inputs within the same cycle. Internally, a first 4-bit binary adder forms the raw sum. A small detector then decides whether that raw value has left the range zero to nine. A second 4-bit adder adds either six or zero to bring the digit back into decimal form.

Several copies can be placed side by side to add numbers of many digits. Each copy's carry output feeds the carry input of the next more significant digit. A separate flag reports when either operand digit holds one of the six codes above nine. While that flag is high, the sum and carry outputs carry no meaning.

Top module: `bcd_digit_adder`

## Requirements
- R1: With both operand digits in 0..9, when a + b + carry-in is at most 9, the sum digit equals that raw value and the carry output is 0.
- R2: With both operand digits in 0..9, when a + b + carry-in lies in 10..15, the sum digit equals the raw value plus six, modulo 16, and the carry output is 1.
- R3: With both operand digits in 0..9, when a + b + carry-in lies in 16..19, the sum digit equals the raw value minus ten, and the carry output is 1. For example, 9 + 9 + 1 gives digit 9 with carry 1.
- R4: The carry input adds exactly one unit to the decimal result. Valid inputs never produce a sum digit above 9, and 10·carry-out + digit equals a + b + carry-in.
- R5: The carry output is 1 exactly when the raw sum of valid digits is 10 or more.
- R6: The invalid-digit flag is 1 exactly when a > 9 or b > 9 (codes 1010 to 1111 on a 4-bit digit), independent of the carry input.
- R7: Two copies, with the lower copy's carry output wired to the upper copy's carry input, add two-digit decimal numbers correctly, including the carry across the digit boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_dig | input | 4 | First operand digit, BCD |
| b_dig | input | 4 | Second operand digit, BCD |
| c_in | input | 1 | Decimal carry from the less significant digit |
| sum_dig | output | 4 | Corrected BCD sum digit |
| c_out | output | 1 | Decimal carry to the more significant digit |
| bad_digit | output | 1 | High when either operand is not a decimal digit |

## Verification
Every valid pair of digits is applied with both values of the carry input. This separates the pass-through range, the 10..15 band where the first adder leaves an invalid code, and the 16..19 band where the first adder's own carry must trigger the correction. Random codes that include 10..15 on one or both operands show that the invalid-digit flag ignores the carry input. A two-copy chain driven with random and directed two-digit operands, such as 99 + 99 with carry in, shows that the carry crosses the digit boundary correctly.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned DIGIT_W   = 4;
  localparam int unsigned DIGIT_MAX = 9;
  localparam int unsigned FIX_CONST = 16 - (DIGIT_MAX + 1);
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/bcd_ripple_adder.sv
module bcd_ripple_adder #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] carry;

  assign carry[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic half_s;
    assign half_s     = x[i] ^ y[i];
    assign s[i]       = half_s ^ carry[i];
    assign carry[i+1] = (x[i] & y[i]) | (half_s & carry[i]);
  end

  assign co = carry[W];
endmodule

// File: rtl/bcd_fix_detect.sv
module bcd_fix_detect (
  input  logic [3:0] raw_z,
  input  logic       raw_k,
  output logic       fix
);
  // Raw value >= 10: first-stage carry, or 1x1x / 11xx codes.
  assign fix = raw_k | (raw_z[3] & (raw_z[2] | raw_z[1]));
endmodule

// File: rtl/bcd_range_check.sv
module bcd_range_check (
  input  logic [3:0] dig,
  output logic       over_nine
);
  assign over_nine = dig[3] & (dig[2] | dig[1]);
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
  import bcd_pkg::*;
(
  input  logic [3:0] a_dig,
  input  logic [3:0] b_dig,
  input  logic       c_in,
  output logic [3:0] sum_dig,
  output logic       c_out,
  output logic       bad_digit
);
  digit_t raw_z;
  logic   raw_k;
  logic   fix;
  digit_t fix_addend;
  logic   stage2_co;
  logic   a_bad;
  logic   b_bad;

  bcd_ripple_adder #(.W(DIGIT_W)) u_stage1 (
    .x  (a_dig),
    .y  (b_dig),
    .ci (c_in),
    .s  (raw_z),
    .co (raw_k)
  );

  bcd_fix_detect u_detect (
    .raw_z (raw_z),
    .raw_k (raw_k),
    .fix   (fix)
  );

  assign fix_addend = fix ? digit_t'(FIX_CONST) : '0;

  bcd_ripple_adder #(.W(DIGIT_W)) u_stage2 (
    .x  (raw_z),
    .y  (fix_addend),
    .ci (1'b0),
    .s  (sum_dig),
    .co (stage2_co)
  );

  bcd_range_check u_chk_a (.dig(a_dig), .over_nine(a_bad));
  bcd_range_check u_chk_b (.dig(b_dig), .over_nine(b_bad));

  assign c_out     = fix;
  assign bad_digit = a_bad | b_bad;
endmodule

// File: rtl/bcd_digit_adder_chk.sv
module bcd_digit_adder_chk (
  input logic [3:0] a_dig,
  input logic [3:0] b_dig,
  input logic       c_in,
  input logic [3:0] sum_dig,
  input logic       c_out,
  input logic       bad_digit,
  input logic       stage2_co
);
  logic [4:0] raw;
  logic       inputs_known;
  logic       valid;

  always_comb begin
    raw          = {1'b0, a_dig} + {1'b0, b_dig} + {4'b0, c_in};
    inputs_known = !$isunknown({a_dig, b_dig, c_in, sum_dig, c_out, bad_digit, stage2_co});
    valid        = (a_dig <= 4'd9) && (b_dig <= 4'd9);
  end

  always_comb begin
    if (inputs_known) begin
      if (valid && raw <= 5'd9)
        a_r1_pass: assert ({1'b0, sum_dig} == raw && !c_out);
      if (valid && raw >= 5'd10 && raw <= 5'd15)
        a_r2_add_six: assert (sum_dig == raw[3:0] + 4'd6 && c_out);
      if (valid && raw >= 5'd16)
        a_r3_high_band: assert ({1'b0, sum_dig} == raw - 5'd10 && c_out);
      if (valid)
        a_r4_digit_range: assert (sum_dig <= 4'd9);
      if (valid)
        a_r5_carry_when_ten: assert (c_out == (raw >= 5'd10));
      a_r6_bad_flag: assert (bad_digit == (a_dig > 4'd9 || b_dig > 4'd9));
      if (stage2_co)
        a_r5_dropped_carry_implies_fix: assert (c_out);
    end
  end
endmodule

bind bcd_digit_adder bcd_digit_adder_chk u_chk (
  .a_dig     (a_dig),
  .b_dig     (b_dig),
  .c_in      (c_in),
  .sum_dig   (sum_dig),
  .c_out     (c_out),
  .bad_digit (bad_digit),
  .stage2_co (stage2_co)
);

// File: tb/bcd_digit_adder_bench.sv
module bcd_digit_adder_bench;
  logic clk;
  logic rst_n;
  logic [3:0] a_dig, b_dig, sum_dig;
  logic       c_in, c_out, bad_digit;
  logic [3:0] a_hi, b_hi, sum_hi;
  logic       c_hi, bad_hi;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  bcd_digit_adder u_bcd_digit_adder (
    .a_dig(a_dig), .b_dig(b_dig), .c_in(c_in),
    .sum_dig(sum_dig), .c_out(c_out), .bad_digit(bad_digit)
  );

  bcd_digit_adder u_hi (
    .a_dig(a_hi), .b_dig(b_hi), .c_in(c_out),
    .sum_dig(sum_hi), .c_out(c_hi), .bad_digit(bad_hi)
  );

  function automatic int exp_digit(int a, int b, int c);
    return (a + b + c) % 10;
  endfunction

  function automatic int exp_carry(int a, int b, int c);
    return ((a + b + c) >= 10) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(int a, int b, int c);
    @(negedge clk);
    a_dig = 4'(a); b_dig = 4'(b); c_in = c[0];
    #2;
  endtask

  task automatic check_valid(int a, int b, int c);
    int raw = a + b + c;
    apply(a, b, c);
    if (raw <= 9) begin
      check("R1 digit", sum_dig, raw);
      check("R1 carry", c_out, 0);
    end else if (raw <= 15) begin
      check("R2 digit", sum_dig, (raw + 6) % 16);
      check("R2 carry", c_out, 1);
    end else begin
      check("R3 digit", sum_dig, raw - 10);
      check("R3 carry", c_out, 1);
    end
    check("R4 value", c_out * 10 + sum_dig, raw);
    check("R5 carry", c_out, exp_carry(a, b, c));
    check("R6 flag clear", bad_digit, 0);
  endtask

  task automatic check_chain(int x, int y, int c);
    int total = x + y + c;
    @(negedge clk);
    a_dig = 4'(x % 10); b_dig = 4'(y % 10); c_in = c[0];
    a_hi  = 4'(x / 10); b_hi  = 4'(y / 10);
    #2;
    check("R7 low digit", sum_dig, exp_digit(x % 10, y % 10, c));
    check("R7 high digit", sum_hi, (total / 10) % 10);
    check("R7 carry", c_hi, total / 100);
  endtask

  initial begin
    a_dig = '0; b_dig = '0; c_in = 1'b0; a_hi = '0; b_hi = '0;
    rst_n = 1'b0;
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset idle digit", sum_dig, 0);
    check("R1 reset idle carry", c_out, 0);
    check("R6 reset idle flag", bad_digit, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed corners
    check_valid(8, 5, 0);  // R2: 13 -> 3 carry 1
    check_valid(9, 9, 1);  // R3: 19 -> 9 carry 1
    check_valid(9, 0, 0);  // R1 boundary
    check_valid(9, 0, 1);  // R4: carry in pushes to 10
    check_valid(5, 5, 0);  // R2 lower edge
    check_valid(8, 8, 0);  // R3 lower edge 16

    // Exhaustive valid sweep
    for (int a = 0; a <= 9; a++)
      for (int b = 0; b <= 9; b++)
        for (int c = 0; c <= 1; c++)
          check_valid(a, b, c);

    // Invalid codes: R6 flag, independent of carry-in
    for (int k = 0; k < 60; k++) begin
      int a = int'($urandom_range(15, 0));
      int b = int'($urandom_range(15, 0));
      int c = int'($urandom_range(1, 0));
      apply(a, b, c);
      check("R6 flag", bad_digit, (a > 9 || b > 9) ? 1 : 0);
      apply(a, b, 1 - c);
      check("R6 flag carry-independent", bad_digit, (a > 9 || b > 9) ? 1 : 0);
    end
    apply(10, 0, 0); check("R6 a=10", bad_digit, 1);
    apply(0, 15, 1); check("R6 b=15", bad_digit, 1);

    // Two-digit chain
    check_chain(99, 99, 1);
    check_chain(45, 55, 0);
    check_chain(50, 49, 1);
    for (int k = 0; k < 100; k++)
      check_chain(int'($urandom_range(99, 0)), int'($urandom_range(99, 0)),
                  int'($urandom_range(1, 0)));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule